// File: doc/BRIEF.md
# Power-Management Event Control Register

This block is one 32-bit control and status word of a two-port network device. The host reaches it through a 16-bit register port that carries a half select. It captures energy-detect events from the two ports into sticky status flags. Per-port enables route those flags to a power-management event pin and to a power-management interrupt. The same word holds a self-clearing reset request for an internal management sub-block. The sub-block reports back when it has left reset.

The host port is a plain single-cycle register access with no back-pressure. A write takes effect at the clock edge where `hw_wr` is high. Read data is combinational from the current state and the half select, so no handshake is needed. The event, enable, mode and reset-done pins are plain levels that are sampled on every clock.

Bit map of the 32-bit word. Upper half: bit 17 holds port-2 status and bit 16 holds port-1 status, at upper-half data bits 1 and 0. Lower half: bit 15 is the port-2 enable, bit 14 is the port-1 enable, and bit 10 is the reset request. All other bits are reserved.

Top module: `pme_ctl_reg`

## Requirements
- R1: While and after `rst_n` is low, both halves read 16'h0000 and `pme_pin`, `pme_irq` and `sub_rst_req` are 0. Reads stay valid while reset is held.
- R2: A high `ed_evt[i]` sets status flag i at the next edge. Port 1 is `ed_evt[0]`, at upper data bit 0. Port 2 is `ed_evt[1]`, at upper data bit 1. The flag stays set after the event input falls.
- R3: An upper-half write with data bit i = 1 clears flag i only if `ed_evt[i]` is low in that cycle. If the event is still high, the flag stays 1. Data bit i = 0 leaves the flag unchanged.
- R4: The enables are read/write at lower data bits 15 (port 2) and 14 (port 1). Reserved bits always read 0, and writing them has no effect.
- R5: `hw_half` = 1 selects the upper half and 0 selects the lower half, for both reads and writes. A write never changes the half that is not selected.
- R6: `pme_irq` is 1 exactly while some flag and its enable are both 1, whatever the value of `pme_en`.
- R7: With `pme_mode` = 0 (level), `pme_pin` is 1 exactly while `pme_en` is 1 and some enabled flag is 1.
- R8: With `pme_mode` = 1 (pulse), each 0-to-1 change of some (flag AND enable) bit while `pme_en` is 1 drives `pme_pin` high for exactly 16 cycles. The pulse starts one cycle after `pme_irq` rises, and a new such change reloads the count.
- R9: A lower-half write with data bit 10 = 1 sets the reset bit, and `sub_rst_req` equals that bit. While the bit is 1, all writes to it are ignored.
- R10: The reset bit clears at the first edge where `sub_rst_done` is seen high while the bit is 1. A high `sub_rst_done` while the bit is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_wr | input | 1 | Host write strobe |
| hw_half | input | 1 | Half select: 1 = bits 31:16, 0 = bits 15:0 |
| hw_wdata | input | 16 | Host write data for the selected half |
| hw_rdata | output | 16 | Read data of the selected half |
| ed_evt | input | 2 | Energy-detect event levels, [0] = port 1, [1] = port 2 |
| pme_en | input | 1 | Global enable of the event pin |
| pme_mode | input | 1 | Pin indication: 0 = level, 1 = pulse |
| pme_pin | output | 1 | Power-management event pin |
| pme_irq | output | 1 | Power-management interrupt level |
| sub_rst_req | output | 1 | Reset request to the management sub-block |
| sub_rst_done | input | 1 | Sub-block has left reset |

## Verification
The hardest case to reach is a clear write that lands while its own event input is still high. The stimulus holds `ed_evt[1]` high across an upper-half write of ones, and only then drops it and writes again. A second hard case is a write to the reset bit while it is already set. The bench sets the bit, holds `sub_rst_done` low, writes zeros and then ones, and only afterwards raises the done input. The 16-cycle pulse is also checked against a retrigger: a second port's flag rises part-way through a running pulse.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int PORTS     = 2;
  localparam int HALF_W    = 16;
  // field positions inside each 16-bit half
  localparam int STS_LSB   = 0;   // upper half
  localparam int EN_LSB    = 14;  // lower half
  localparam int RST_BIT   = 10;  // lower half
  typedef enum logic {
    PME_LEVEL = 1'b0,
    PME_PULSE = 1'b1
  } pme_mode_e;
endpackage

// File: rtl/pme_status.sv
module pme_status #(
  parameter int PORTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PORTS-1:0] evt,
  input  logic [PORTS-1:0] clr,
  output logic [PORTS-1:0] sts
);
  for (genvar i = 0; i < PORTS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sts[i] <= 1'b0;
      else if (evt[i]) sts[i] <= 1'b1;
      else if (clr[i]) sts[i] <= 1'b0;
    end

    // R3
    evt_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> sts[i]);
    // R2
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !clr[i]) |=> sts[i]);
  end
endmodule

// File: rtl/pme_pulse.sv
module pme_pulse #(
  parameter int PORTS = 2,
  parameter int LEN   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PORTS-1:0] act,
  input  logic             arm,
  output logic             busy
);
  localparam int CW = $clog2(LEN + 1);

  logic [PORTS-1:0] act_q;
  logic [CW-1:0]    cnt;
  logic             load;

  assign load = arm && (|(act & ~act_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt   <= '0;
    end else begin
      act_q <= act;
      if (load)          cnt <= CW'(LEN);
      else if (cnt != 0) cnt <= cnt - CW'(1);
    end
  end

  assign busy = (cnt != 0);

  // R8
  pulse_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt == $past(cnt) - CW'(1)));
  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
endmodule

// File: rtl/pme_rst_req.sv
module pme_rst_req (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic done,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            req <= 1'b0;
    else if (req)          req <= !done;
    else if (set_req)      req <= 1'b1;
  end

  // R10
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && done) |=> !req);
  // R9
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !done) |=> req);
endmodule

// File: rtl/pme_ctl_reg.sv
module pme_ctl_reg
  import pme_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_wr,
  input  logic        hw_half,
  input  logic [15:0] hw_wdata,
  output logic [15:0] hw_rdata,
  input  logic [1:0]  ed_evt,
  input  logic        pme_en,
  input  logic        pme_mode,
  output logic        pme_pin,
  output logic        pme_irq,
  output logic        sub_rst_req,
  input  logic        sub_rst_done
);
  logic [PORTS-1:0] sts;
  logic [PORTS-1:0] en_q;
  logic [PORTS-1:0] clr;
  logic [PORTS-1:0] act;
  logic             wr_hi, wr_lo;
  logic             pulse_busy;
  logic             is_pulse;
  logic             unused_wdata;

  assign wr_hi    = hw_wr &&  hw_half;
  assign wr_lo    = hw_wr && !hw_half;
  assign clr      = wr_hi ? hw_wdata[STS_LSB +: PORTS] : '0;
  assign is_pulse = (pme_mode == PME_PULSE);
  assign unused_wdata = ^{hw_wdata[13:11], hw_wdata[9:2]};

  pme_status #(.PORTS(PORTS)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(ed_evt), .clr(clr), .sts(sts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_lo) en_q <= hw_wdata[EN_LSB +: PORTS];
  end

  assign act = sts & en_q;

  pme_pulse #(.PORTS(PORTS), .LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .act(act), .arm(pme_en && is_pulse),
    .busy(pulse_busy)
  );

  pme_rst_req u_rst (
    .clk(clk), .rst_n(rst_n), .set_req(wr_lo && hw_wdata[RST_BIT]),
    .done(sub_rst_done), .req(sub_rst_req)
  );

  assign pme_irq = |act;
  assign pme_pin = is_pulse ? pulse_busy : (pme_en && pme_irq);

  always_comb begin
    hw_rdata = '0;
    if (hw_half) begin
      hw_rdata[STS_LSB +: PORTS] = sts;
    end else begin
      hw_rdata[EN_LSB +: PORTS] = en_q;
      hw_rdata[RST_BIT]         = sub_rst_req;
    end
  end

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pme_irq |-> (|sts));
  // R7
  level_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_pulse && !pme_en) |-> !pme_pin);
  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_half ? (hw_rdata[15:2] == '0) : (hw_rdata[13:11] == '0 && hw_rdata[9:0] == '0));
endmodule

// File: tb/pme_ctl_reg_tb.sv
module pme_ctl_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_wr = 1'b0, hw_half = 1'b0;
  logic [15:0] hw_wdata = '0;
  logic [15:0] hw_rdata;
  logic [1:0]  ed_evt = '0;
  logic        pme_en = 1'b0, pme_mode = 1'b0;
  logic        pme_pin, pme_irq, sub_rst_req;
  logic        sub_rst_done = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pme_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .hw_wr(hw_wr), .hw_half(hw_half),
    .hw_wdata(hw_wdata), .hw_rdata(hw_rdata), .ed_evt(ed_evt),
    .pme_en(pme_en), .pme_mode(pme_mode), .pme_pin(pme_pin),
    .pme_irq(pme_irq), .sub_rst_req(sub_rst_req), .sub_rst_done(sub_rst_done)
  );

  // behavioural reference model
  bit [1:0] m_sts, m_en, m_prev;
  bit       m_rst;
  int       m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_prev = 0; m_rst = 0; m_cnt = 0;
    end else begin
      bit [1:0] a;
      a = m_sts & m_en;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (pme_en && pme_mode && ((a & ~m_prev) != 0)) m_cnt = 16;
      m_prev = a;
      if (hw_wr && hw_half) m_sts = m_sts & ~hw_wdata[1:0];
      m_sts = m_sts | ed_evt;
      if (m_rst) begin
        if (sub_rst_done) m_rst = 0;
      end else if (hw_wr && !hw_half && hw_wdata[10]) m_rst = 1;
      if (hw_wr && !hw_half) m_en = hw_wdata[15:14];
    end
  end

  function automatic logic [15:0] m_rd();
    return hw_half ? {14'b0, m_sts} : {m_en, 3'b0, m_rst, 10'b0};
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (!finished) begin
    chk("R1/R4/R5 rdata", hw_rdata, m_rd());
    chk("R6 irq", 16'(pme_irq), 16'(|(m_sts & m_en)));
    chk("R7/R8 pin", 16'(pme_pin), 16'(pme_mode ? (m_cnt != 0) : (pme_en && |(m_sts & m_en))));
    chk("R9/R10 req", 16'(sub_rst_req), 16'(m_rst));
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); #1; end
  endtask

  task automatic wr(logic half, logic [15:0] d);
    hw_half = half; hw_wdata = d; hw_wr = 1'b1;
    tick();
    hw_wr = 1'b0; hw_wdata = '0;
  endtask

  task automatic rd(logic half, string tag, logic [15:0] exp);
    hw_half = half; #1;
    chk(tag, hw_rdata, exp);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      finished = 1; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    #1;
    // R1: readable while reset held
    rd(1, "R1 upper in reset", 16'h0000);
    rd(0, "R1 lower in reset", 16'h0000);
    chk("R1 outputs in reset", {13'b0, pme_pin, pme_irq, sub_rst_req}, 16'h0000);
    tick(2);
    rst_n = 1'b1;
    tick();
    // R2: sticky capture
    ed_evt = 2'b01; tick(); ed_evt = 2'b00; tick();
    rd(1, "R2 port1 flag sticky", 16'h0001);
    chk("R6 no irq with enable off", 16'(pme_irq), 16'h0000);
    // R3: clear while event active
    ed_evt = 2'b10; tick();
    wr(1, 16'h0003);
    rd(1, "R3 flag stays while event active", 16'h0002);
    ed_evt = 2'b00;
    wr(1, 16'h0000);
    rd(1, "R3 write of zero keeps flag", 16'h0002);
    wr(1, 16'h0002);
    rd(1, "R3 clear once event inactive", 16'h0000);
    // R4/R9: enables and reset bit, reserved ignored
    wr(0, 16'hFFFF);
    rd(0, "R4 enables and reserved", 16'hC400);
    chk("R9 req asserted", 16'(sub_rst_req), 16'h0001);
    wr(0, 16'h0000);
    rd(0, "R9 write ignored while set", 16'h0400);
    wr(0, 16'h0400);
    tick(3);
    rd(0, "R9 held without done", 16'h0400);
    sub_rst_done = 1'b1; tick(); sub_rst_done = 1'b0;
    rd(0, "R10 cleared by done", 16'h0000);
    sub_rst_done = 1'b1; tick(2); sub_rst_done = 1'b0;
    rd(0, "R10 done while clear no effect", 16'h0000);
    // R5: half isolation
    wr(1, 16'hC400);
    rd(0, "R5 upper write leaves lower", 16'h0000);
    ed_evt = 2'b01; tick(); ed_evt = 2'b00;
    wr(0, 16'h0003);
    rd(1, "R5 lower write leaves upper", 16'h0001);
    wr(1, 16'h0001);
    // R6/R7: irq without global enable, level pin
    pme_en = 1'b0; pme_mode = 1'b0;
    wr(0, 16'h4000);
    ed_evt = 2'b01; tick(); ed_evt = 2'b00; tick();
    chk("R6 irq with pme_en off", 16'(pme_irq), 16'h0001);
    chk("R7 pin low with pme_en off", 16'(pme_pin), 16'h0000);
    pme_en = 1'b1; #1;
    chk("R7 level pin high", 16'(pme_pin), 16'h0001);
    wr(1, 16'h0001);
    chk("R7 level pin drops after clear", 16'(pme_pin), 16'h0000);
    // R8: pulse length
    pme_mode = 1'b1;
    wr(0, 16'h8000);
    ed_evt = 2'b10; tick(); ed_evt = 2'b00;
    hi = 0;
    for (int k = 0; k < 30; k++) begin tick(); if (pme_pin) hi++; end
    chk("R8 pulse length", 16'(hi), 16'd16);
    // R8: retrigger by second port mid-pulse
    wr(1, 16'h0002);
    wr(0, 16'hC000);
    ed_evt = 2'b10; tick(); ed_evt = 2'b00;
    tick(6);
    ed_evt = 2'b01; tick(); ed_evt = 2'b00;
    hi = 0;
    for (int k = 0; k < 30; k++) begin tick(); if (pme_pin) hi++; end
    chk("R8 retrigger reloads", 16'(hi), 16'd16);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule